// File: doc/BRIEF.md
# Iterative Non-Restoring Signed Divider

This block divides a signed 32-bit dividend by a signed 16-bit divisor. It produces a quotient of a chosen precision by repeating a one-bit divide step, one step per clock. A 36-bit accumulator holds the working value. Its upper twenty bits carry the partial remainder, and quotient bits enter at its low end through a single carry flag.

Each step makes a choice from two sign bits: the accumulator's top bit and the divisor's top bit. If they are equal, the step subtracts the divisor; if they differ, it adds the divisor. The step first shifts the accumulator left by one and then applies the divisor at bits 31..16. The dividend's magnitude is what gets loaded, so the quotient formed in the low bits is always a magnitude. The sign is applied at the end. The last partial remainder may overshoot below zero, and a final correction adds the divisor magnitude back when that happens.

A caller pulses `start_i` together with the operands and a step count N. It then waits for `done_o`. A rejected request finishes at once and raises `err_o`.

Top module: `nrdiv_unit`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `done_o` and `err_o` are 0, and `quo_o` and `rem_o` are 0.
- R2: A valid request is taken at the first clock edge with `start_i` high and `busy_o` low. `busy_o` is high for the next N+1 cycles. At the N+1-th edge after acceptance, `busy_o` falls and `done_o` is high for one cycle with `err_o` low.
- R3: A `start_i` pulse while `busy_o` is high is ignored. The running division completes with its own operands and timing, and no extra `done_o` appears.
- R4: For step count N in 2..16, `|quo_o|` equals floor(|D|·2^N / (|S|·2^16)). The value fits in 16 bits.
- R5: `quo_o` is a 17-bit two's-complement value. It is negative exactly when the dividend sign (bit 31) differs from the divisor sign (bit 15) and the magnitude is nonzero.
- R6: `rem_o` is a 32-bit two's-complement value with `|rem_o|` = |D|·2^N − |quo_o|·|S|·2^16, which gives 0 ≤ `|rem_o|` < |S|·2^16. Its sign follows the dividend.
- R7: A zero divisor is rejected. `done_o` and `err_o` are high one edge after acceptance, `busy_o` never rises, and `quo_o` and `rem_o` read 0.
- R8: A request with |D| ≥ |S|·2^16 is rejected in the same way as R7. This includes the equality case and the most negative dividend.
- R9: A step count outside 2..16 (including 0, 1 and 17) is rejected in the same way as R7.
- R10: No result is saturated. A quotient magnitude of 0xFFFF at N = 16 is reported exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, sampled when idle |
| dividend_i | input | 32 | Signed dividend D |
| divisor_i | input | 16 | Signed divisor S |
| steps_i | input | 5 | Quotient precision N (step count) |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Last completion was a rejection; valid with done_o |
| quo_o | output | 17 | Signed quotient |
| rem_o | output | 32 | Signed corrected remainder, scaled by 2^N |

## Verification
The assertions assume that a result leaves the block only after the operands were checked against R7 to R9. They therefore take for granted that every accepted divisor is nonzero and that the dividend magnitude sits below the scaled divisor. Under those conditions the remainder bound and the quotient sign hold in every completed cycle. To keep within that envelope, the stimulus draws each random dividend as a value reduced modulo the scaled divisor magnitude and then signs it at random. The out-of-range operands and illegal step counts are kept in separate directed requests that must come back as rejections.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    localparam int DVD_W     = 32;
    localparam int DSR_W     = 16;
    localparam int GUARD_W   = 4;
    localparam int ACC_W     = DVD_W + GUARD_W;
    localparam int LOW_W     = DVD_W - DSR_W;
    localparam int UP_W      = ACC_W - LOW_W;
    localparam int CNT_W     = $clog2(DSR_W + 1);
    localparam int QUO_W     = DSR_W + 1;
    localparam int MIN_STEPS = 2;
    localparam int MAX_STEPS = DSR_W;

    typedef logic [ACC_W-1:0] acc_t;
    typedef logic [DSR_W-1:0] dsr_t;
    typedef logic [DVD_W-1:0] dvd_t;
    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [QUO_W-1:0] quo_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_FIX  = 2'd2
    } state_e;

    typedef struct packed {
        acc_t acc;
        logic carry;
    } step_t;

    typedef struct packed {
        logic quo_neg;
        logic rem_neg;
        dsr_t dsr;
        cnt_t steps;
    } job_t;

    function automatic dvd_t dvd_mag(input dvd_t v);
        return v[DVD_W-1] ? dvd_t'(-v) : v;
    endfunction

    function automatic dsr_t dsr_mag(input dsr_t v);
        return v[DSR_W-1] ? dsr_t'(-v) : v;
    endfunction

    function automatic dvd_t dsr_scaled(input dsr_t m);
        return {m, {LOW_W{1'b0}}};
    endfunction

    function automatic logic steps_ok(input cnt_t n);
        return (n >= cnt_t'(MIN_STEPS)) && (n <= cnt_t'(MAX_STEPS));
    endfunction

    function automatic logic operands_ok(input dvd_t d, input dsr_t s);
        return (s != '0) && (dvd_mag(d) < dsr_scaled(dsr_mag(s)));
    endfunction

endpackage

// File: rtl/nrdiv_step.sv
module nrdiv_step
    import nrdiv_pkg::*;
(
    input  step_t cur_i,
    input  dsr_t  dsr_i,
    output step_t nxt_o
);

    logic             do_add;
    logic [ACC_W-1:0] shifted;
    logic [UP_W-1:0]  upper;
    logic [UP_W-1:0]  dext;
    logic [UP_W-1:0]  upd;

    always_comb begin
        // sign disagreement selects addition, agreement selects subtraction
        do_add  = cur_i.acc[ACC_W-1] ^ dsr_i[DSR_W-1];
        shifted = {cur_i.acc[ACC_W-2:0], cur_i.carry};
        upper   = shifted[ACC_W-1:LOW_W];
        dext    = {{(UP_W-DSR_W){dsr_i[DSR_W-1]}}, dsr_i};
        upd     = do_add ? (upper + dext) : (upper - dext);
        nxt_o.acc   = {upd, shifted[LOW_W-1:0]};
        // next quotient bit: remainder still nonnegative
        nxt_o.carry = ~upd[UP_W-1];
    end

endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
    import nrdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic reject_i,
    input  cnt_t steps_i,
    output logic load_o,
    output logic reject_o,
    output logic step_o,
    output logic fix_o,
    output logic busy_o
);

    state_e state_q;
    cnt_t   cnt_q;
    cnt_t   steps_q;
    logic   accept;

    always_comb begin
        accept   = start_i && (state_q == ST_IDLE);
        load_o   = accept && !reject_i;
        reject_o = accept && reject_i;
        step_o   = (state_q == ST_STEP);
        fix_o    = (state_q == ST_FIX);
        busy_o   = (state_q != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            steps_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (load_o) begin
                        state_q <= ST_STEP;
                        cnt_q   <= '0;
                        steps_q <= steps_i;
                    end
                end
                ST_STEP: begin
                    cnt_q <= cnt_q + cnt_t'(1);
                    if (cnt_q == steps_q - cnt_t'(1)) begin
                        state_q <= ST_FIX;
                    end
                end
                ST_FIX:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4: the fix-up stage is reached after exactly the requested step count
    p_fix_count_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FIX) |-> (cnt_q == steps_q));

    // R2: the step counter never runs past the request while stepping
    p_step_window_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STEP) |-> (cnt_q < steps_q));

    // R9: only legal step counts ever reach the stepping state
    p_legal_steps_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STEP) |->
        ((steps_q >= cnt_t'(MIN_STEPS)) && (steps_q <= cnt_t'(MAX_STEPS))));

endmodule

// File: rtl/nrdiv_fixup.sv
module nrdiv_fixup
    import nrdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fix_i,
    input  step_t fin_i,
    input  job_t  job_i,
    output quo_t  quo_o,
    output dvd_t  rem_o
);

    logic [DSR_W-1:0] keep;
    logic [DSR_W-1:0] formed;
    acc_t             partial;
    acc_t             restored;
    dvd_t             rmag;

    always_comb begin
        for (int i = 0; i < DSR_W; i++) begin
            keep[i] = (i < int'(job_i.steps));
        end
        // final quotient bit still sits in the carry flag
        formed  = {fin_i.acc[DSR_W-2:0], fin_i.carry} & keep;
        quo_o   = job_i.quo_neg ? quo_t'(-{1'b0, formed}) : {1'b0, formed};
        partial = fin_i.acc & ~{{(ACC_W-DSR_W){1'b0}}, keep};
        // a negative final partial remainder is brought back by one divisor
        restored = partial[ACC_W-1]
                 ? (partial + {{GUARD_W{1'b0}}, dsr_scaled(dsr_mag(job_i.dsr))})
                 : partial;
        rmag    = restored[DVD_W-1:0];
        rem_o   = job_i.rem_neg ? dvd_t'(-rmag) : rmag;
    end

    // R6: the restored remainder always fits the 32-bit magnitude range
    p_rem_guard_r6: assert property (@(posedge clk) disable iff (rst)
        fix_i |-> (restored[ACC_W-1:DVD_W] == '0));

endmodule

// File: rtl/nrdiv_unit.sv
module nrdiv_unit
    import nrdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [31:0] dividend_i,
    input  logic [15:0] divisor_i,
    input  logic [4:0]  steps_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o,
    output logic [16:0] quo_o,
    output logic [31:0] rem_o
);

    step_t cur_q;
    step_t nxt;
    job_t  job_q;
    logic  reject;
    logic  load;
    logic  rej_take;
    logic  step_en;
    logic  fix_en;
    dvd_t  load_mag;
    quo_t  fix_quo;
    dvd_t  fix_rem;

    always_comb begin
        reject   = !steps_ok(cnt_t'(steps_i)) || !operands_ok(dividend_i, divisor_i);
        load_mag = dvd_mag(dividend_i);
    end

    nrdiv_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .reject_i (reject),
        .steps_i  (cnt_t'(steps_i)),
        .load_o   (load),
        .reject_o (rej_take),
        .step_o   (step_en),
        .fix_o    (fix_en),
        .busy_o   (busy_o)
    );

    nrdiv_step u_step (
        .cur_i (cur_q),
        .dsr_i (job_q.dsr),
        .nxt_o (nxt)
    );

    nrdiv_fixup u_fixup (
        .clk   (clk),
        .rst   (rst),
        .fix_i (fix_en),
        .fin_i (cur_q),
        .job_i (job_q),
        .quo_o (fix_quo),
        .rem_o (fix_rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            job_q  <= '0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
            quo_o  <= '0;
            rem_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (load) begin
                cur_q.acc   <= {{GUARD_W{load_mag[DVD_W-1]}}, load_mag};
                cur_q.carry <= 1'b0;
                job_q       <= '{quo_neg: dividend_i[DVD_W-1] ^ divisor_i[DSR_W-1],
                                 rem_neg: dividend_i[DVD_W-1],
                                 dsr:     divisor_i,
                                 steps:   cnt_t'(steps_i)};
            end else if (step_en) begin
                cur_q <= nxt;
            end
            if (rej_take) begin
                done_o <= 1'b1;
                err_o  <= 1'b1;
                quo_o  <= '0;
                rem_o  <= '0;
            end else if (fix_en) begin
                done_o <= 1'b1;
                err_o  <= 1'b0;
                quo_o  <= fix_quo;
                rem_o  <= fix_rem;
            end
        end
    end

    // R2: busy drops exactly when a good result is presented
    p_done_at_fall_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (done_o && !err_o));

    // R7: a rejection never engages the sequencer and reports zeros
    p_reject_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> (!busy_o && (quo_o == '0) && (rem_o == '0)));

    // R5: a nonzero quotient carries the combined operand sign
    p_quo_sign_r5: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o && (quo_o != '0)) |-> (quo_o[QUO_W-1] == job_q.quo_neg));

    // R6: the reported remainder stays below the scaled divisor magnitude
    p_rem_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o) |-> (dvd_mag(rem_o) < dsr_scaled(dsr_mag(job_q.dsr))));

endmodule

// File: tb/nrdiv_unit_bench.sv
`timescale 1ns/1ps
module nrdiv_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] dividend_i = '0;
    logic [15:0] divisor_i = '0;
    logic [4:0]  steps_i = '0;
    logic        busy_o;
    logic        done_o;
    logic        err_o;
    logic [16:0] quo_o;
    logic [31:0] rem_o;

    typedef struct packed {
        logic        err;
        logic [16:0] quo;
        logic [31:0] rem;
        logic [31:0] due;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          failures = 0;
    int unsigned cyc = 0;
    int unsigned seed = 32'h1357_9bdf;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nrdiv_unit u_nrdiv_unit (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .steps_i    (steps_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o),
        .quo_o      (quo_o),
        .rem_o      (rem_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [31:0] d, input logic [15:0] s, input int n);
        longint sd, ss, u, v, qq, rr;
        exp_t   e;
        e  = '0;
        sd = longint'($signed(d));
        ss = longint'($signed(s));
        u  = (sd < 0) ? -sd : sd;
        v  = (ss < 0) ? -ss : ss;
        // R7 R8 R9: rejection conditions
        if (ss == 0 || n < 2 || n > 16 || u >= (v << 16)) begin
            e.err = 1'b1;
            return e;
        end
        qq = (u << n) / (v << 16);
        rr = (u << n) % (v << 16);
        if ((sd < 0) != (ss < 0)) qq = -qq;
        if (sd < 0) rr = -rr;
        e.quo = qq[16:0];
        e.rem = rr[31:0];
        return e;
    endfunction

    task automatic issue(input logic [31:0] d, input logic [15:0] s, input int n, output exp_t e);
        e = model(d, s, n);
        @(negedge clk);
        dividend_i = d;
        divisor_i  = s;
        steps_i    = 5'(n);
        start_i    = 1'b1;
        e.due = e.err ? (cyc + 1) : (cyc + 1 + n + 1);
        sb.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        if (e.err) check(busy_o == 1'b0, "R7 busy stays low", busy_o, 0);
        else       check(busy_o == 1'b1, "R2 busy after accept", busy_o, 1);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic run_op(input logic [31:0] d, input logic [15:0] s, input int n);
        exp_t e;
        issue(d, s, n, e);
        drain();
    endtask

    // R3: a second request while busy must leave the first one untouched
    task automatic run_busy_start(input logic [31:0] d, input logic [15:0] s, input int n);
        exp_t e;
        issue(d, s, n, e);
        repeat (2) @(negedge clk);
        dividend_i = 32'h0000_1000;
        divisor_i  = 16'h0001;
        steps_i    = 5'd3;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R3 busy held", busy_o, 1);
        drain();
        repeat (6) @(negedge clk);
        check(done_o == 1'b0 && busy_o == 1'b0, "R3 no extra run", {busy_o, done_o}, 0);
    endtask

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(cyc == e.due, "R2 done timing", cyc, e.due);
                check(busy_o == 1'b0, "R2 busy low at done", busy_o, 0);
                check(err_o == e.err, "R7 R8 R9 error flag", err_o, e.err);
                check(quo_o == e.quo, "R4 R5 R10 quotient",
                      longint'($signed(quo_o)), longint'($signed(e.quo)));
                check(rem_o == e.rem, "R6 remainder",
                      longint'($signed(rem_o)), longint'($signed(e.rem)));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check({busy_o, done_o, err_o} == 3'b000, "R1 flags in reset", {busy_o, done_o, err_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(quo_o == '0 && rem_o == '0, "R1 outputs after reset", quo_o, 0);
        check({busy_o, done_o, err_o} == 3'b000, "R1 flags after reset", {busy_o, done_o, err_o}, 0);

        // R4: positive operands, several precisions
        run_op(32'h2000_0000, 16'h4000, 16);
        run_op(32'h1234_5678, 16'h5000, 16);
        run_op(32'h1234_5678, 16'h5000, 2);
        run_op(32'h1234_5678, 16'h5000, 7);
        run_op(32'h1234_5678, 16'h5000, 15);
        // R5 R6: sign combinations
        run_op(32'h2000_0000, 16'hC000, 16);
        run_op(32'hEDCB_A988, 16'h5000, 16);
        run_op(32'hEDCB_A988, 16'hB000, 12);
        run_op(32'h0000_0001, 16'hFFFF, 16);
        // R10: full-scale quotient without saturation
        run_op(32'h7FFE_FFFF, 16'h7FFF, 16);
        run_op(32'h8000_0001, 16'h8000, 16);
        // R7 R8 R9: rejections
        run_op(32'h0000_1000, 16'h0000, 16);
        run_op(32'h4000_0000, 16'h4000, 16);
        run_op(32'h8000_0000, 16'h8000, 16);
        run_op(32'h7FFF_FFFF, 16'h7FFF, 16);
        run_op(32'h0000_1000, 16'h4000, 1);
        run_op(32'h0000_1000, 16'h4000, 0);
        run_op(32'h0000_1000, 16'h4000, 17);
        // R3: start while busy
        run_busy_start(32'h3000_0000, 16'h7000, 10);
        // R4 R5 R6: random in-range requests
        for (int k = 0; k < 40; k++) begin
            logic [15:0] s;
            logic [31:0] d;
            longint      lim, mag;
            int          n;
            s = 16'(rnd());
            if (s == 16'h0000) s = 16'h0001;
            lim = (longint'($signed(s)) < 0 ? -longint'($signed(s)) : longint'($signed(s))) << 16;
            mag = longint'(rnd()) % lim;
            d = (rnd() & 1) ? 32'(-mag) : 32'(mag);
            n = 2 + int'(rnd() % 15);
            run_op(d, s, n);
        end
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule